// File: doc/BRIEF.md
# Supervisory Watchdog and Reset Sequencer

This block keeps a processor in reset while its supply is not good, and stretches that reset for a fixed time once power-good returns. After release, it watches a kick line that the processor software must toggle. If the line sits at one level for longer than the watchdog period, the block issues a reset pulse of fixed length. It also latches a watchdog fault flag that only a fresh kick edge clears.

A plan input selects one of two timeout schemes. In standard mode every watchdog period is the same. In fast mode the period is short, except for the first period after each reset release, which is long. This gives boot code time to start kicking. A disable input stands for an unconnected kick pin: it parks the watchdog but leaves power-fail resets working.

All durations are counted in ticks from a free-running prescaler. Every period and the prescaler ratio are parameters.

Top module: `sup_wdog_top`

## Requirements
- R1: While `pwr_good_i` is low, `sys_rst_o` is 1 and `sys_rst_no` is 0 in the same cycle. This holds whatever the kick, plan and disable inputs do. No watchdog timeout can happen in that time.
- R2: Reset releases RST_TICKS ticks after the first clock edge that samples `pwr_good_i` high. With one tick per clock, `sys_rst_o` reads high for RST_TICKS-1 further samples after that edge.
- R3: Either a rising or a falling change on `kick_i` restarts the watchdog count. The change passes a two-flop synchronizer and an edge detector, so the count restarts on the third clock edge after the change. A one-clock pulse on `kick_i` also counts.
- R4: With `fast_mode_i` = 0, if no kick edge arrives for WD_STD_TICKS ticks after release or after the last kick, reset asserts for exactly RST_TICKS ticks. With the kick held, reset alternates between WD_STD_TICKS ticks low and RST_TICKS ticks high.
- R5: `wd_fault_no` goes low on the edge that starts a watchdog reset. It stays low after that reset ends, until the next kick edge clears it.
- R6: With `fast_mode_i` = 1, the first timeout after each reset release is WD_FIRST_TICKS. Every timeout after a kick edge is WD_FAST_TICKS. The reset pulse stays RST_TICKS.
- R7: While `wd_disable_i` = 1, the watchdog count is held at zero and no watchdog reset occurs. After it drops, a full period counts from zero.
- R8: `wd_fault_no` is forced to 1 in the same cycle whenever `pwr_good_i` is 0 or `wd_disable_i` is 1.
- R9: One tick occurs every TICK_DIV clocks. A watchdog-caused reset pulse then lasts TICK_DIV*RST_TICKS clocks, and the held-kick low time lasts TICK_DIV*WD_STD_TICKS clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block itself |
| pwr_good_i | input | 1 | Synchronous supply-good indication, 1 = supply above threshold |
| kick_i | input | 1 | Watchdog kick line from the processor, asynchronous |
| fast_mode_i | input | 1 | Timeout plan: 0 = standard, 1 = fast with long first period |
| wd_disable_i | input | 1 | 1 = watchdog parked (floating kick pin) |
| sys_rst_o | output | 1 | Processor reset, active high |
| sys_rst_no | output | 1 | Processor reset, active low |
| wd_fault_no | output | 1 | Latched watchdog fault, active low |

## Verification
A held kick line checks the exact power-up stretch, the periodic pulse width and the pulse spacing. It is run in both plans, which separates the standard period from the long first period of fast mode. Single rising and single falling kick changes are placed just after a release. This shows that each polarity restarts the count and pins down the synchronizer latency, and it separates the fast short period from the first period. Regular toggles and one-clock pulses must hold reset off indefinitely. Disable and power-loss windows confirm that the fault flag is forced high and the count is parked. A second instance with a divided tick confirms that the scaled pulse and spacing lengths are exact.

// File: rtl/sup_pkg.sv
`timescale 1ns/1ps
package sup_pkg;

  typedef enum logic {
    WD_PLAN_STD  = 1'b0,
    WD_PLAN_FAST = 1'b1
  } wd_plan_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sup_tick_gen.sv
`timescale 1ns/1ps
module sup_tick_gen #(
  parameter int unsigned TICK_DIV = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  generate
    if (TICK_DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             pre_q <= '0;
        else if (pre_q == LAST)  pre_q <= '0;
        else                     pre_q <= pre_q + 1'b1;
      end

      assign tick_o = (pre_q == LAST);

      // R9
      tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/sup_kick_edge.sv
`timescale 1ns/1ps
module sup_kick_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic edge_o
);

  // [0],[1] synchronizer, [2] previous synchronized level
  logic [2:0] kq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kq <= '0;
    else         kq <= {kq[1:0], kick_i};
  end

  assign edge_o = kq[1] ^ kq[2];

endmodule

// File: rtl/sup_rst_stretch.sv
`timescale 1ns/1ps
module sup_rst_stretch #(
  parameter int unsigned RST_TICKS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pwr_good_i,
  input  logic wd_expire_i,
  output logic rst_active_o
);

  localparam int unsigned CW = $clog2(RST_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_TICKS - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (!pwr_good_i || wd_expire_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q && tick_i) begin
      if (cnt_q == LAST) active_q <= 1'b0;
      else               cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign rst_active_o = active_q;

  // R1
  pwr_low_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> active_q);

  // R2
  release_needs_pwr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> $past(pwr_good_i));

  // R4
  expire_starts_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_expire_i |=> (active_q && cnt_q == '0));

endmodule

// File: rtl/sup_wdog_timer.sv
`timescale 1ns/1ps
module sup_wdog_timer
  import sup_pkg::*;
#(
  parameter int unsigned WD_STD_TICKS   = 1600,
  parameter int unsigned WD_FAST_TICKS  = 100,
  parameter int unsigned WD_FIRST_TICKS = 1600
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     kick_edge_i,
  input  logic     pwr_good_i,
  input  logic     rst_active_i,
  input  logic     disable_i,
  input  wd_plan_e plan_i,
  output logic     expire_o,
  output logic     fault_o
);

  localparam int unsigned WD_MAX = max_u(max_u(WD_STD_TICKS, WD_FAST_TICKS), WD_FIRST_TICKS);
  localparam int unsigned CW     = $clog2(WD_MAX + 1);

  logic [CW-1:0] cnt_q, lim;
  logic          first_q, fault_q, hold;

  always_comb begin
    unique case (plan_i)
      WD_PLAN_FAST: lim = first_q ? CW'(WD_FIRST_TICKS) : CW'(WD_FAST_TICKS);
      default:      lim = CW'(WD_STD_TICKS);
    endcase
  end

  assign hold     = !pwr_good_i || rst_active_i || disable_i;
  // >= keeps a plan change mid-period from skipping the limit
  assign expire_o = !hold && !kick_edge_i && tick_i && (cnt_q >= lim - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
      fault_q <= 1'b0;
    end else begin
      if (hold || kick_edge_i || expire_o) cnt_q <= '0;
      else if (tick_i)                     cnt_q <= cnt_q + 1'b1;

      if (rst_active_i)     first_q <= 1'b1;
      else if (kick_edge_i) first_q <= 1'b0;

      if (!pwr_good_i || disable_i) fault_q <= 1'b0;
      else if (kick_edge_i)         fault_q <= 1'b0;
      else if (expire_o)            fault_q <= 1'b1;
    end
  end

  assign fault_o = fault_q;

  // R3
  kick_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_edge_i |=> (cnt_q == '0));

  // R5
  fault_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && pwr_good_i && !disable_i && !kick_edge_i) |=> fault_q);

  // R7
  disable_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |=> (cnt_q == '0));

  // R8
  fault_forced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_good_i || disable_i) |=> !fault_q);

endmodule

// File: rtl/sup_wdog_top.sv
`timescale 1ns/1ps
module sup_wdog_top
  import sup_pkg::*;
#(
  parameter int unsigned TICK_DIV       = 50000,
  parameter int unsigned RST_TICKS      = 200,
  parameter int unsigned WD_STD_TICKS   = 1600,
  parameter int unsigned WD_FAST_TICKS  = 100,
  parameter int unsigned WD_FIRST_TICKS = 1600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic kick_i,
  input  logic fast_mode_i,
  input  logic wd_disable_i,
  output logic sys_rst_o,
  output logic sys_rst_no,
  output logic wd_fault_no
);

  logic     tick, kick_edge, expire, rst_active, fault;
  wd_plan_e plan;

  assign plan = wd_plan_e'(fast_mode_i);

  sup_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  sup_kick_edge u_kick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .kick_i(kick_i),
    .edge_o(kick_edge)
  );

  sup_wdog_timer #(
    .WD_STD_TICKS  (WD_STD_TICKS),
    .WD_FAST_TICKS (WD_FAST_TICKS),
    .WD_FIRST_TICKS(WD_FIRST_TICKS)
  ) u_wdog (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .kick_edge_i (kick_edge),
    .pwr_good_i  (pwr_good_i),
    .rst_active_i(rst_active),
    .disable_i   (wd_disable_i),
    .plan_i      (plan),
    .expire_o    (expire),
    .fault_o     (fault)
  );

  sup_rst_stretch #(.RST_TICKS(RST_TICKS)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .pwr_good_i  (pwr_good_i),
    .wd_expire_i (expire),
    .rst_active_o(rst_active)
  );

  assign sys_rst_o   = rst_active | ~pwr_good_i;
  assign sys_rst_no  = ~sys_rst_o;
  assign wd_fault_no = ~(fault & pwr_good_i & ~wd_disable_i);

  // R1
  no_wd_timeout_unpowered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |-> !expire);

endmodule

// File: tb/sup_wdog_top_tb_top.sv
`timescale 1ns/1ps
module sup_wdog_top_tb_top;

  localparam int unsigned DIV2  = 3;
  localparam int unsigned RST   = 8;
  localparam int unsigned STD   = 40;
  localparam int unsigned FAST  = 10;
  localparam int unsigned FIRST = 30;

  logic clk = 1'b0;
  logic rst_n, pwr, kick, fast, dis;
  logic sys_rst, sys_rst_n, fault_n;
  logic d2_rst, d2_rst_n, d2_fault_n;
  int   checks = 0;
  int   errors = 0;

  always #10 clk = ~clk;

  sup_wdog_top #(.TICK_DIV(1), .RST_TICKS(RST), .WD_STD_TICKS(STD),
                 .WD_FAST_TICKS(FAST), .WD_FIRST_TICKS(FIRST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr), .kick_i(kick),
    .fast_mode_i(fast), .wd_disable_i(dis),
    .sys_rst_o(sys_rst), .sys_rst_no(sys_rst_n), .wd_fault_no(fault_n));

  sup_wdog_top #(.TICK_DIV(DIV2), .RST_TICKS(RST), .WD_STD_TICKS(STD),
                 .WD_FAST_TICKS(FAST), .WD_FIRST_TICKS(FIRST)) dut_div_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr), .kick_i(kick),
    .fast_mode_i(fast), .wd_disable_i(dis),
    .sys_rst_o(d2_rst), .sys_rst_no(d2_rst_n), .wd_fault_no(d2_fault_n));

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts consecutive negedge samples at level lvl, starting with the present one.
  task automatic run_len(input bit sel, input logic lvl, output int n);
    n = 0;
    while (((sel ? d2_rst : sys_rst) == lvl) && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int bad = 0;
    rst_n = 1'b0; pwr = 1'b0; kick = 1'b0; fast = 1'b0; dis = 1'b0;
    #45;
    chk("R1 reset state sys_rst_o", sys_rst, 1);
    chk("R1 reset state sys_rst_no", sys_rst_n, 0);
    chk("R8 reset state wd_fault_no", fault_n, 1);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 2 * STD; i++) begin
      @(negedge clk);
      if (sys_rst !== 1'b1 || sys_rst_n !== 1'b0 || fault_n !== 1'b1) bad++;
    end
    chk("R1 unpowered long idle, cycles off", bad, 0);
  endtask

  task automatic t_powerup_held();
    int n;
    @(negedge clk) pwr = 1'b1;
    @(negedge clk);
    run_len(0, 1'b1, n); chk("R2 power-up stretch", n, RST - 1);
    run_len(0, 1'b0, n); chk("R4 first std period", n, STD);
    chk("R5 fault low at timeout", fault_n, 0);
    run_len(0, 1'b1, n); chk("R4 wd pulse width", n, RST);
    chk("R5 fault stays low after pulse", fault_n, 0);
    run_len(0, 1'b0, n); chk("R4 held-kick spacing", n, STD);
  endtask

  task automatic t_fault_clear();
    int n;
    run_len(0, 1'b1, n);
    kick = 1'b1;
    @(negedge clk); chk("R5 fault low 1 clk after kick", fault_n, 0);
    @(negedge clk); chk("R5 fault low 2 clk after kick", fault_n, 0);
    @(negedge clk); chk("R5 fault cleared by kick edge", fault_n, 1);
    run_len(0, 1'b0, n); chk("R3 rising kick restarts", n, STD);
    run_len(0, 1'b1, n);
    kick = 1'b0;
    run_len(0, 1'b0, n); chk("R3 falling kick restarts", n, STD + 3);
  endtask

  task automatic t_keepalive();
    int n;
    int bad = 0;
    run_len(0, 1'b1, n);
    for (int i = 0; i < 10; i++) begin
      kick = ~kick;
      for (int j = 0; j < 20; j++) begin
        @(negedge clk);
        if (sys_rst !== 1'b0) bad++;
      end
    end
    chk("R3 toggled kick keeps reset off", bad, 0);
    bad = 0;
    kick = 1'b0;
    for (int i = 0; i < 8; i++) begin
      kick = 1'b1;
      @(negedge clk);
      if (sys_rst !== 1'b0) bad++;
      kick = 1'b0;
      for (int j = 0; j < 24; j++) begin
        @(negedge clk);
        if (sys_rst !== 1'b0) bad++;
      end
    end
    chk("R3 one-clock pulses keep reset off", bad, 0);
    run_len(0, 1'b0, n);
  endtask

  task automatic t_fast();
    int n;
    fast = 1'b1;
    run_len(0, 1'b1, n); chk("R6 pulse width fast", n, RST);
    run_len(0, 1'b0, n); chk("R6 first period after release", n, FIRST);
    run_len(0, 1'b1, n);
    kick = ~kick;
    run_len(0, 1'b0, n); chk("R6 fast period after kick", n, FAST + 3);
    run_len(0, 1'b1, n); chk("R6 pulse width after fast timeout", n, RST);
    run_len(0, 1'b0, n); chk("R6 long period again after reset", n, FIRST);
    fast = 1'b0;
  endtask

  task automatic t_disable();
    int n;
    int bad = 0;
    run_len(0, 1'b1, n);
    chk("R5 fault latched before disable", fault_n, 0);
    dis = 1'b1;
    #1;
    chk("R8 disable forces fault high", fault_n, 1);
    for (int i = 0; i < 3 * STD; i++) begin
      @(negedge clk);
      if (sys_rst !== 1'b0 || fault_n !== 1'b1) bad++;
    end
    chk("R7 no wd reset while disabled", bad, 0);
    dis = 1'b0;
    run_len(0, 1'b0, n); chk("R7 full period after disable drops", n, STD);
  endtask

  task automatic t_power_loss();
    int n;
    int bad = 0;
    run_len(0, 1'b1, n);
    chk("R5 fault latched before power loss", fault_n, 0);
    pwr = 1'b0;
    #1;
    chk("R1 power loss sys_rst_o", sys_rst, 1);
    chk("R1 power loss sys_rst_no", sys_rst_n, 0);
    chk("R8 power loss forces fault high", fault_n, 1);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      kick = ~kick;
      if (sys_rst !== 1'b1 || fault_n !== 1'b1) bad++;
    end
    chk("R1 held while unpowered", bad, 0);
    @(negedge clk) pwr = 1'b1;
    @(negedge clk);
    run_len(0, 1'b1, n); chk("R2 stretch after power return", n, RST - 1);
  endtask

  task automatic t_prescale();
    int n;
    int guard = 0;
    while (d2_rst !== 1'b0 && guard < 2000) begin @(negedge clk); guard++; end
    while (d2_rst !== 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
    run_len(1, 1'b1, n); chk("R9 divided pulse width", n, DIV2 * RST);
    run_len(1, 1'b0, n); chk("R9 divided spacing", n, DIV2 * STD);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all: actual %0d expected %0d", 150000, 0);
    finish_run();
  end

  initial begin
    t_reset();
    t_powerup_held();
    t_fault_clear();
    t_keepalive();
    t_fast();
    t_disable();
    t_power_loss();
    t_prescale();
    finish_run();
  end

endmodule